// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vectoring

This block holds the interrupt state that two serial channels, A and B, share. Each channel reports two kinds of event: a received character is available, and the transmit buffer has emptied. For each channel the block tracks whether each kind is pending and whether it is under service. Receive and transmit share one service slot per channel, so at most one of them is under service at a time. The block also keeps a single 8-bit vector that names the interrupt under service. The vector uses one of two encodings. The status-high select input picks between them at the moment the vector is loaded.

A host-side decoder maps its register reads onto `vec_o`, the vector, and `pend_o`, the pending bits. It maps its write commands onto one-cycle strobes: raise an event, clear a transmit interrupt, or clear the interrupt under service. Each channel has its own enables, which gate the pending bits and the break condition into a request. The requests of both channels are ORed, and the result leaves the block as one registered interrupt line.

Top module: `sio_irq_vector`

## Requirements
- R1: While `rst_n` is low, and until the first strobe after it rises, `vec_o` is 0x00, `pend_o` bits 5,4,2,1 are 0 and `irq_o` is 0.
- R2: A receive strobe sets that channel's receive pending bit (`pend_o[5]` for A, `pend_o[2]` for B) one edge later. If that channel has no transmit interrupt under service, the receive interrupt becomes the one under service and its code is loaded into `vec_o`.
- R3: A transmit strobe sets that channel's transmit pending bit (`pend_o[4]` for A, `pend_o[1]` for B). If that channel has no receive interrupt under service, the transmit interrupt becomes the one under service and its code is loaded into `vec_o`.
- R4: With `stat_hi`=0 the vector codes are: A receive 0x0C, A transmit 0x08, B receive 0x04, B transmit 0x00, nothing 0x06.
- R5: With `stat_hi`=1 the vector codes are: A receive 0x30, A transmit 0x10, B receive 0x20, nothing 0x60. B transmit stays 0x00.
- R6: An event that arrives while the other kind in the same channel is under service only sets its pending bit. `vec_o` keeps its value.
- R7: A transmit-clear strobe clears that channel's transmit pending bit and loads the nothing code. If that channel's receive interrupt is still pending, the receive interrupt then becomes the one under service and `vec_o` takes its code.
- R8: A clear-under-service strobe clears the channel's receive interrupt if it is under service. Otherwise it clears the transmit interrupt if that one is under service. With nothing under service the strobe changes nothing.
- R9: When a receive interrupt is cleared while that channel's transmit interrupt is pending, the transmit interrupt becomes the one under service and `vec_o` takes its code.
- R10: A channel requests an interrupt when any of these holds:
  - transmit is enabled and transmit is pending;
  - its receive mode is 01 or 10 and receive is pending (modes 00 and 11 give no receive request);
  - break is enabled and the break status is set.
- R11: `irq_o` is the OR of both channels' requests. It is registered: it changes only on the clock edge after the strobe or enable change that causes it.
- R12: `pend_o[3]` (A) and `pend_o[0]` (B) show the channel's enabled break condition, `brk_ie & brk_st`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_hi | input | 1 | Vector encoding select: 1 high-bit codes, 0 low-bit codes |
| rx_ev | input | 2 | Receive-available strobes, bit 0 A, bit 1 B |
| tx_ev | input | 2 | Transmit-empty strobes, bit 0 A, bit 1 B |
| tx_clr | input | 2 | Clear transmit interrupt strobes |
| ius_clr | input | 2 | Clear highest under-service strobes |
| tx_ie | input | 2 | Transmit interrupt enables |
| rx_mode_a | input | 2 | Channel A receive interrupt mode |
| rx_mode_b | input | 2 | Channel B receive interrupt mode |
| brk_ie | input | 2 | Break interrupt enables |
| brk_st | input | 2 | Break status flags |
| vec_o | output | 8 | Interrupt vector |
| pend_o | output | 6 | Pending bits: 5 A rx, 4 A tx, 3 A brk, 2 B rx, 1 B tx, 0 B brk |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that at most one of the eight command strobes is high in any cycle. The strobes are processed in a fixed order, and the checks on pending bits one edge after a strobe rely on no other strobe acting on the same cycle. The stimulus drives each strobe alone for exactly one cycle, with idle cycles between strobes. It changes enables, mode and break inputs only on cycles with no strobe, so every expected vector follows from one event at a time.

// File: rtl/sio_ivec_pkg.sv
package sio_ivec_pkg;
    localparam int NCH    = 2;
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;
    localparam int VEC_W  = 8;
    localparam int RXM_W  = 2;
    localparam int PEND_W = 3 * NCH;

    typedef enum logic [1:0] {SRC_RX, SRC_TX, SRC_NONE} src_e;

    typedef struct packed {
        logic [NCH-1:0]   rx_p;
        logic [NCH-1:0]   tx_p;
        logic [NCH-1:0]   rx_us;
        logic [NCH-1:0]   tx_us;
        logic [VEC_W-1:0] vec;
    } ivec_st_t;

    function automatic logic [VEC_W-1:0] vec_code(src_e src, logic is_b, logic hi);
        logic [VEC_W-1:0] v;
        case (src)
            SRC_RX:  v = hi ? (is_b ? 8'h20 : 8'h30) : (is_b ? 8'h04 : 8'h0C);
            SRC_TX:  v = is_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/sio_ivec_req.sv
module sio_ivec_req
    import sio_ivec_pkg::*;
(
    input  logic             rx_pend,
    input  logic             tx_pend,
    input  logic             tx_en,
    input  logic [RXM_W-1:0] rx_mode,
    input  logic             brk_en,
    input  logic             brk_flag,
    output logic             req
);
    logic rx_mode_on;

    always_comb begin
        rx_mode_on = (rx_mode == 2'b01) || (rx_mode == 2'b10);
        req        = (tx_en && tx_pend) || (rx_mode_on && rx_pend) || (brk_en && brk_flag);
    end
endmodule

// File: rtl/sio_ivec_core.sv
module sio_ivec_core
    import sio_ivec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_hi,
    input  logic [NCH-1:0]   rx_ev,
    input  logic [NCH-1:0]   tx_ev,
    input  logic [NCH-1:0]   tx_clr,
    input  logic [NCH-1:0]   ius_clr,
    output logic [NCH-1:0]   rx_p_q,
    output logic [NCH-1:0]   tx_p_q,
    output logic [NCH-1:0]   rx_p_d,
    output logic [NCH-1:0]   tx_p_d,
    output logic [VEC_W-1:0] vec_q
);
    ivec_st_t st_q, st_d;

    function automatic ivec_st_t raise_rx(ivec_st_t s, int c, logic hi);
        ivec_st_t r = s;
        r.rx_p[c] = 1'b1;
        if (!r.tx_us[c]) begin
            r.rx_us[c] = 1'b1;
            r.vec      = vec_code(SRC_RX, c == CH_B, hi);
        end
        return r;
    endfunction

    function automatic ivec_st_t raise_tx(ivec_st_t s, int c, logic hi);
        ivec_st_t r = s;
        r.tx_p[c] = 1'b1;
        if (!r.rx_us[c]) begin
            r.tx_us[c] = 1'b1;
            r.vec      = vec_code(SRC_TX, c == CH_B, hi);
        end
        return r;
    endfunction

    function automatic ivec_st_t drop_rx(ivec_st_t s, int c, logic hi);
        ivec_st_t r = s;
        r.rx_p[c]  = 1'b0;
        r.rx_us[c] = 1'b0;
        r.vec      = vec_code(SRC_NONE, c == CH_B, hi);
        if (r.tx_p[c]) r = raise_tx(r, c, hi);
        return r;
    endfunction

    function automatic ivec_st_t drop_tx(ivec_st_t s, int c, logic hi);
        ivec_st_t r = s;
        r.tx_p[c]  = 1'b0;
        r.tx_us[c] = 1'b0;
        r.vec      = vec_code(SRC_NONE, c == CH_B, hi);
        if (r.rx_p[c]) r = raise_rx(r, c, hi);
        return r;
    endfunction

    always_comb begin
        ivec_st_t nx;
        nx = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (rx_ev[c])  nx = raise_rx(nx, c, stat_hi);
            if (tx_ev[c])  nx = raise_tx(nx, c, stat_hi);
            if (tx_clr[c]) nx = drop_tx(nx, c, stat_hi);
            if (ius_clr[c]) begin
                if (nx.rx_us[c])      nx = drop_rx(nx, c, stat_hi);
                else if (nx.tx_us[c]) nx = drop_tx(nx, c, stat_hi);
            end
        end
        st_d = nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_p_q = st_q.rx_p;
    assign tx_p_q = st_q.tx_p;
    assign rx_p_d = st_d.rx_p;
    assign tx_p_d = st_d.tx_p;
    assign vec_q  = st_q.vec;

    // Input contract: one command strobe per cycle (see brief).
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ev, tx_ev, tx_clr, ius_clr}));

    a_r6_slot_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rx_us & st_q.tx_us) == '0);

    a_r8_service_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.rx_us & ~st_q.rx_p) == '0) && ((st_q.tx_us & ~st_q.tx_p) == '0));

    a_r2_rx_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_ev) |=> ((st_q.rx_p & $past(rx_ev)) == $past(rx_ev)));

    a_r7_tx_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_clr) |=> ((st_q.tx_p & $past(tx_clr)) == '0));
endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
    import sio_ivec_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stat_hi,
    input  logic [1:0]   rx_ev,
    input  logic [1:0]   tx_ev,
    input  logic [1:0]   tx_clr,
    input  logic [1:0]   ius_clr,
    input  logic [1:0]   tx_ie,
    input  logic [1:0]   rx_mode_a,
    input  logic [1:0]   rx_mode_b,
    input  logic [1:0]   brk_ie,
    input  logic [1:0]   brk_st,
    output logic [7:0]   vec_o,
    output logic [5:0]   pend_o,
    output logic         irq_o
);
    logic [NCH-1:0]   rx_p_q, tx_p_q, rx_p_d, tx_p_d;
    logic [NCH-1:0]   chan_req;
    logic [NCH-1:0]   brk_on;
    logic [RXM_W-1:0] rx_mode [NCH];
    logic             irq_d, irq_q;

    assign rx_mode[CH_A] = rx_mode_a;
    assign rx_mode[CH_B] = rx_mode_b;
    assign brk_on        = brk_ie & brk_st;

    sio_ivec_core core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_hi (stat_hi),
        .rx_ev   (rx_ev),
        .tx_ev   (tx_ev),
        .tx_clr  (tx_clr),
        .ius_clr (ius_clr),
        .rx_p_q  (rx_p_q),
        .tx_p_q  (tx_p_q),
        .rx_p_d  (rx_p_d),
        .tx_p_d  (tx_p_d),
        .vec_q   (vec_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_req
        sio_ivec_req req_i (
            .rx_pend  (rx_p_d[g]),
            .tx_pend  (tx_p_d[g]),
            .tx_en    (tx_ie[g]),
            .rx_mode  (rx_mode[g]),
            .brk_en   (brk_ie[g]),
            .brk_flag (brk_st[g]),
            .req      (chan_req[g])
        );
    end

    always_comb begin
        irq_d = |chan_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o  = irq_q;
    assign pend_o = {rx_p_q[CH_A], tx_p_q[CH_A], brk_on[CH_A],
                     rx_p_q[CH_B], tx_p_q[CH_B], brk_on[CH_B]};

    a_r11_quiet_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o == 6'd0 && rx_ev == 2'b00 && tx_ev == 2'b00) |=> !irq_o);

    a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie == 2'b00 && brk_ie == 2'b00 && rx_mode_a == 2'b00 && rx_mode_b == 2'b00)
        |=> !irq_o);
endmodule

// File: tb/sio_irq_vector_tb_top.sv
module sio_irq_vector_tb_top;
    localparam int K_NONE = 0, K_RX = 1, K_TX = 2, K_TXCLR = 3, K_IUS = 4;
    localparam int A = 0, B = 1;

    logic clk = 1'b0, rst_n = 1'b0, stat_hi = 1'b0;
    logic [1:0] rx_ev = '0, tx_ev = '0, tx_clr = '0, ius_clr = '0;
    logic [1:0] tx_ie = 2'b11, rx_mode_a = 2'b01, rx_mode_b = 2'b10;
    logic [1:0] brk_ie = '0, brk_st = '0;
    logic [7:0] vec_o;
    logic [5:0] pend_o;
    logic       irq_o;

    int n_chk = 0, n_bad = 0;
    logic last_irq = 1'b0;
    logic [14:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    sio_irq_vector dut_i (
        .clk(clk), .rst_n(rst_n), .stat_hi(stat_hi),
        .rx_ev(rx_ev), .tx_ev(tx_ev), .tx_clr(tx_clr), .ius_clr(ius_clr),
        .tx_ie(tx_ie), .rx_mode_a(rx_mode_a), .rx_mode_b(rx_mode_b),
        .brk_ie(brk_ie), .brk_st(brk_st),
        .vec_o(vec_o), .pend_o(pend_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [14:0] got, input logic [14:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got vec=%h pend=%b irq=%b, expected vec=%h pend=%b irq=%b",
                     tag, got[14:7], got[6:1], got[0], exp[14:7], exp[6:1], exp[0]);
        end
    endtask

    // Driver: called at a falling edge; applies one command and queues the result.
    task automatic step(input int kind, input int ch, input logic [7:0] ev,
                        input logic [5:0] ep, input logic ei, input string tag);
        case (kind)
            K_RX:    rx_ev[ch]   = 1'b1;
            K_TX:    tx_ev[ch]   = 1'b1;
            K_TXCLR: tx_clr[ch]  = 1'b1;
            K_IUS:   ius_clr[ch] = 1'b1;
            default: ;
        endcase
        #1;
        n_chk++;
        if (irq_o !== last_irq) begin
            n_bad++;
            $display("FAIL R11 %s: irq moved before the edge, got %b expected %b", tag, irq_o, last_irq);
        end
        exp_q.push_back({ev, ep, ei});
        tag_q.push_back(tag);
        last_irq = ei;
        @(negedge clk);
        rx_ev = '0; tx_ev = '0; tx_clr = '0; ius_clr = '0;
    endtask

    // Monitor: compares the queued expectation just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), {vec_o, pend_o, irq_o}, exp_q.pop_front());
        end
    end

    initial begin
        #(8 * 20000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 reset held", {vec_o, pend_o, irq_o}, {8'h00, 6'b0, 1'b0});
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {vec_o, pend_o, irq_o}, {8'h00, 6'b0, 1'b0});

        // Low encoding
        step(K_RX, A, 8'h0C, 6'h20, 1, "R2 R4 A rx");
        step(K_IUS, A, 8'h06, 6'h00, 0, "R8 clear A rx");
        step(K_TX, B, 8'h00, 6'h02, 1, "R3 R4 B tx");
        step(K_RX, B, 8'h00, 6'h06, 1, "R6 B rx blocked");
        step(K_TXCLR, B, 8'h04, 6'h04, 1, "R7 B txclr reraises rx");
        step(K_IUS, B, 8'h06, 6'h00, 0, "R8 clear B rx");
        step(K_TX, A, 8'h08, 6'h10, 1, "R3 R4 A tx");
        step(K_RX, A, 8'h08, 6'h30, 1, "R6 A rx blocked");
        step(K_IUS, A, 8'h0C, 6'h20, 1, "R8 R7 A ius clears tx");
        step(K_TX, A, 8'h0C, 6'h30, 1, "R6 A tx blocked");
        step(K_IUS, A, 8'h08, 6'h10, 1, "R9 rx clear reraises tx");
        step(K_TXCLR, A, 8'h06, 6'h00, 0, "R7 A txclr");
        step(K_IUS, A, 8'h06, 6'h00, 0, "R8 nothing under service");

        // High encoding
        stat_hi = 1'b1;
        step(K_RX, A, 8'h30, 6'h20, 1, "R5 A rx");
        step(K_IUS, A, 8'h60, 6'h00, 0, "R5 none");
        step(K_RX, B, 8'h20, 6'h04, 1, "R5 B rx");
        step(K_IUS, B, 8'h60, 6'h00, 0, "R5 none B");
        step(K_TX, A, 8'h10, 6'h10, 1, "R5 A tx");
        step(K_TXCLR, A, 8'h60, 6'h00, 0, "R5 A txclr");
        step(K_TX, B, 8'h00, 6'h02, 1, "R5 B tx");
        step(K_TXCLR, B, 8'h60, 6'h00, 0, "R5 B txclr");

        // Receive mode gating
        rx_mode_a = 2'b00;
        step(K_RX, A, 8'h30, 6'h20, 0, "R10 mode 00");
        rx_mode_a = 2'b11;
        step(K_NONE, A, 8'h30, 6'h20, 0, "R10 mode 11");
        rx_mode_a = 2'b10;
        step(K_NONE, A, 8'h30, 6'h20, 1, "R10 mode 10");
        rx_mode_a = 2'b01;
        step(K_IUS, A, 8'h60, 6'h00, 0, "R10 clear");

        // Transmit enable gating
        tx_ie = 2'b01;
        step(K_TX, B, 8'h00, 6'h02, 0, "R10 B tx disabled");
        tx_ie = 2'b11;
        step(K_NONE, B, 8'h00, 6'h02, 1, "R10 B tx enabled");
        step(K_TXCLR, B, 8'h60, 6'h00, 0, "R10 B txclr");

        // Break
        brk_st = 2'b01;
        step(K_NONE, A, 8'h60, 6'h00, 0, "R12 A brk masked");
        brk_ie = 2'b01;
        step(K_NONE, A, 8'h60, 6'h08, 1, "R12 A brk");
        brk_ie = 2'b11; brk_st = 2'b10;
        step(K_NONE, B, 8'h60, 6'h01, 1, "R12 B brk");
        brk_st = 2'b00;
        step(K_NONE, B, 8'h60, 6'h00, 0, "R12 brk off");

        // Both channels requesting
        step(K_TX, A, 8'h10, 6'h10, 1, "R11 A tx");
        step(K_RX, B, 8'h20, 6'h14, 1, "R11 B rx own slot");
        step(K_TXCLR, A, 8'h60, 6'h04, 1, "R11 B keeps irq");
        step(K_IUS, B, 8'h60, 6'h00, 0, "R11 all clear");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule